// File: doc/BRIEF.md
# Threshold Hit-Mask Builder and Packet Assembler

This block performs per-event zero suppression for 256 readout channels, arranged as four groups of 64. When an event is accepted, every channel value is compared against that channel's own programmable threshold. The result is one hit bit per channel. The four 64-bit group masks form one 256-bit (32-byte) record, and records are collected into packets. Each packet is one header beat followed by 25 record beats on a ready/valid stream.

A second path serves the readout that follows an external selection step. A downstream selector decides which channels matter and sends their indices back as coordinates. For each coordinate in range, the block returns the stored value of that channel from the most recently accepted event. A coordinate outside the channel range produces no data and raises a sticky error flag.

The event input is back-pressured. The block holds one record at a time. While that record is still waiting to leave, no new event is taken, so no event is ever dropped.

Top module: `hitmask_packer`

## Requirements
- R1: After reset, `pk_valid`, `rd_valid` and `crd_err` are 0, `ev_ready` is 1, and every channel threshold is 4095, so no channel can register a hit.
- R2: A channel's hit bit is 1 exactly when its 12-bit value is strictly greater than its threshold. A value equal to the threshold gives 0.
- R3: In a record, bit 64*g+c is channel c of group g. Channel k's value sits at `ev_vals[12*k +: 12]`, where k = 64*g+c.
- R4: Each packet is one header beat followed by 25 record beats in acceptance order. `pk_last` is 1 on the 25th record beat only.
- R5: Header beat fields: bits [31:0] hold the event number of the packet's first record, bits [39:32] hold the record count 25, and all other bits are 0. Events are numbered from 0, counting accepted events since reset.
- R6: While `pk_valid` is 1 and `pk_ready` is 0, `pk_valid`, `pk_data` and `pk_last` hold their values.
- R7: An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both 1. `ev_ready` is 0 while a record is still held, and every accepted event appears in the output exactly once.
- R8: A write with `thr_we` = 1 sets the threshold of channel `thr_addr` to `thr_data`. The new threshold applies to events accepted on later clock edges.
- R9: When `crd_valid` is 1 and `crd_idx` < 256, the next cycle shows `rd_valid` = 1, `rd_chan` = `crd_idx`, and `rd_data` = that channel's value in the most recently accepted event.
- R10: When `crd_valid` is 1 and `crd_idx` >= 256, the coordinate is ignored. `rd_valid` is 0 in the next cycle, and `crd_err` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | 8 | Channel whose threshold is written |
| thr_data | input | 12 | New threshold value |
| ev_valid | input | 1 | Event values present |
| ev_ready | output | 1 | Block can take an event |
| ev_vals | input | 3072 | 256 channel values, 12 bits each, channel k at bits 12k |
| pk_valid | output | 1 | Packet beat present |
| pk_ready | input | 1 | Downstream takes the beat |
| pk_data | output | 256 | Header or record beat |
| pk_last | output | 1 | Final beat of a packet |
| crd_valid | input | 1 | Coordinate present |
| crd_idx | input | 9 | Requested channel index |
| rd_valid | output | 1 | Readout value present |
| rd_chan | output | 8 | Channel of the readout value |
| rd_data | output | 12 | Stored channel value |
| crd_err | output | 1 | Sticky out-of-range coordinate flag |

## Verification
Four kinds of input are used:
- Values that all sit at the 4095 reset threshold, which show the reset thresholds and the strict comparison.
- Values equal to a per-channel threshold ramp and then one above it. These separate "greater than" from "greater or equal" on every channel at once.
- Single-channel walking hits in each group. These expose any swap in group order or bit order inside the record.
- Random values under random downstream stalls. These cross two packet boundaries and check header numbering, `pk_last` placement and loss-free back-pressure.

Coordinates at both ends of the range and just beyond it separate valid readout from the ignored case.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  typedef enum logic [0:0] {PH_HDR = 1'b0, PH_REC = 1'b1} pk_phase_t;

  // Hit rule: strictly above the threshold (R2)
  function automatic logic hmp_hit(input logic [31:0] val, input logic [31:0] thr);
    return val > thr;
  endfunction

  // Header beat layout (R5): event number low, record count next, rest zero
  function automatic logic [255:0] hmp_header(input logic [31:0] first_ev, input logic [7:0] count);
    logic [255:0] h;
    h = '0;
    h[31:0]  = first_ev;
    h[39:32] = count;
    return h;
  endfunction

endpackage

// File: rtl/hmp_thr_bank.sv
module hmp_thr_bank #(
  parameter int NCH = 256,
  parameter int VW  = 12,
  parameter int AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [VW-1:0]     wdata,
  output logic [NCH*VW-1:0] thr_flat
);
  logic [VW-1:0] thr_q [NCH];

  // R1 reset to all-ones, R8 single-channel write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) thr_q[i] <= '1;
    end else if (we) begin
      thr_q[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_flat
    assign thr_flat[k*VW +: VW] = thr_q[k];
  end
endmodule

// File: rtl/hmp_mask_build.sv
module hmp_mask_build #(
  parameter int NGRP = 4,
  parameter int CPG  = 64,
  parameter int VW   = 12,
  localparam int NCH = NGRP * CPG
) (
  input  logic [NCH*VW-1:0] vals,
  input  logic [NCH*VW-1:0] thrs,
  output logic [NCH-1:0]    mask
);
  import hmp_pkg::*;

  // R3: group g occupies bits [g*CPG +: CPG], channel 0 of the group at the low bit
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar c = 0; c < CPG; c++) begin : g_ch
      localparam int K = g * CPG + c;
      assign mask[K] = hmp_hit(32'(vals[K*VW +: VW]), 32'(thrs[K*VW +: VW]));
    end
  end
endmodule

// File: rtl/hmp_pkt_asm.sv
module hmp_pkt_asm #(
  parameter int REC_W = 256,
  parameter int RECS  = 25,
  parameter int EVW   = 32,
  localparam int SW   = $clog2(RECS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REC_W-1:0] in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [REC_W-1:0] out_data,
  output logic             out_last,
  output logic             in_fire,
  output logic             rec_full,
  output logic             hdr_phase
);
  import hmp_pkg::*;

  logic [REC_W-1:0] rec_q;
  logic             full_q;
  logic [EVW-1:0]   evn_q, ev_ctr_q;
  logic [SW-1:0]    slot_q;
  pk_phase_t        phase_q;
  logic             out_fire;
  logic [255:0]     hdr_w;

  assign rec_full  = full_q;
  assign in_ready  = !full_q;          // R7: one record held at a time
  assign in_fire   = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_fire  = out_valid && out_ready;
  assign hdr_phase = (phase_q == PH_HDR);
  assign hdr_w     = hmp_header(32'(evn_q), 8'(RECS));
  assign out_data  = hdr_phase ? REC_W'(hdr_w) : rec_q;
  assign out_last  = !hdr_phase && (slot_q == SW'(RECS - 1));   // R4

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q    <= '0;
      full_q   <= 1'b0;
      evn_q    <= '0;
      ev_ctr_q <= '0;
      slot_q   <= '0;
      phase_q  <= PH_HDR;
    end else begin
      if (in_fire) begin
        rec_q    <= in_mask;
        full_q   <= 1'b1;
        evn_q    <= ev_ctr_q;
        ev_ctr_q <= ev_ctr_q + 1'b1;
      end
      if (out_fire) begin
        if (hdr_phase) begin
          phase_q <= PH_REC;
        end else begin
          full_q <= 1'b0;
          if (slot_q == SW'(RECS - 1)) begin
            slot_q  <= '0;
            phase_q <= PH_HDR;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hmp_coord_rd.sv
module hmp_coord_rd #(
  parameter int NCH = 256,
  parameter int VW  = 12,
  parameter int AW  = 8,
  localparam int IW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_we,
  input  logic [NCH*VW-1:0] snap_in,
  input  logic              crd_valid,
  input  logic [IW-1:0]     crd_idx,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_chan,
  output logic [VW-1:0]     rd_data,
  output logic              crd_err,
  output logic              crd_bad
);
  logic [VW-1:0] snap_q [NCH];
  logic          in_range;

  assign in_range = crd_idx < IW'(NCH);
  assign crd_bad  = crd_valid && !in_range;

  always_ff @(posedge clk) begin
    if (snap_we) begin
      for (int i = 0; i < NCH; i++) snap_q[i] <= snap_in[i*VW +: VW];
    end
  end

  // R9 readout, R10 ignore with sticky flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_chan  <= '0;
      rd_data  <= '0;
      crd_err  <= 1'b0;
    end else begin
      rd_valid <= crd_valid && in_range;
      if (crd_valid && in_range) begin
        rd_chan <= crd_idx[AW-1:0];
        rd_data <= snap_q[crd_idx[AW-1:0]];
      end
      if (crd_bad) crd_err <= 1'b1;
    end
  end
endmodule

// File: rtl/hitmask_packer.sv
module hitmask_packer #(
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 64,
  parameter int VAL_W        = 12,
  parameter int RECS_PER_PKT = 25,
  parameter int EVN_W        = 32,
  localparam int NCH   = NUM_GROUPS * CH_PER_GROUP,
  localparam int AW    = $clog2(NCH),
  localparam int IW    = AW + 1,
  localparam int REC_W = NCH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 thr_we,
  input  logic [AW-1:0]        thr_addr,
  input  logic [VAL_W-1:0]     thr_data,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [NCH*VAL_W-1:0] ev_vals,
  output logic                 pk_valid,
  input  logic                 pk_ready,
  output logic [REC_W-1:0]     pk_data,
  output logic                 pk_last,
  input  logic                 crd_valid,
  input  logic [IW-1:0]        crd_idx,
  output logic                 rd_valid,
  output logic [AW-1:0]        rd_chan,
  output logic [VAL_W-1:0]     rd_data,
  output logic                 crd_err
);
  logic [NCH*VAL_W-1:0] thr_flat;
  logic [NCH-1:0]       ev_mask;
  logic                 ev_fire;
  logic                 rec_full;
  logic                 hdr_phase;
  logic                 crd_bad;

  hmp_thr_bank #(.NCH(NCH), .VW(VAL_W), .AW(AW)) thr_i (
    .clk(clk), .rst_n(rst_n), .we(thr_we), .waddr(thr_addr),
    .wdata(thr_data), .thr_flat(thr_flat)
  );

  hmp_mask_build #(.NGRP(NUM_GROUPS), .CPG(CH_PER_GROUP), .VW(VAL_W)) mask_i (
    .vals(ev_vals), .thrs(thr_flat), .mask(ev_mask)
  );

  hmp_pkt_asm #(.REC_W(REC_W), .RECS(RECS_PER_PKT), .EVW(EVN_W)) pkt_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ev_valid), .in_ready(ev_ready), .in_mask(ev_mask),
    .out_valid(pk_valid), .out_ready(pk_ready), .out_data(pk_data), .out_last(pk_last),
    .in_fire(ev_fire), .rec_full(rec_full), .hdr_phase(hdr_phase)
  );

  hmp_coord_rd #(.NCH(NCH), .VW(VAL_W), .AW(AW)) crd_i (
    .clk(clk), .rst_n(rst_n), .snap_we(ev_fire), .snap_in(ev_vals),
    .crd_valid(crd_valid), .crd_idx(crd_idx),
    .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_data(rd_data),
    .crd_err(crd_err), .crd_bad(crd_bad)
  );
endmodule

// File: rtl/hitmask_packer_chk.sv
module hitmask_packer_chk #(
  parameter int NCH   = 256,
  parameter int AW    = 8,
  parameter int REC_W = 256,
  parameter int RECS  = 25,
  localparam int IW   = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic             ev_fire,
  input logic             rec_full,
  input logic             hdr_phase,
  input logic             pk_valid,
  input logic             pk_ready,
  input logic [REC_W-1:0] pk_data,
  input logic             pk_last,
  input logic             crd_valid,
  input logic [IW-1:0]    crd_idx,
  input logic             crd_bad,
  input logic             rd_valid,
  input logic [AW-1:0]    rd_chan,
  input logic             crd_err
);
  logic [7:0] beat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (pk_valid && pk_ready) beat_q <= (beat_q == 8'(RECS)) ? 8'd0 : beat_q + 8'd1;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_data) && $stable(pk_last));

  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    rec_full |-> !ev_ready);

  a_r7_fire: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> pk_valid);

  a_r4_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && pk_last |-> beat_q == 8'(RECS) && !hdr_phase);

  a_r4_hdr_first: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && beat_q == 8'd0 |-> !pk_last);

  a_r9_readout: assert property (@(posedge clk) disable iff (!rst_n)
    crd_valid && crd_idx < IW'(NCH) |=> rd_valid && rd_chan == $past(crd_idx[AW-1:0]));

  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    crd_bad |=> !rd_valid && crd_err);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crd_err |=> crd_err);

  a_r7_valid_in: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> ev_valid);
endmodule

bind hitmask_packer hitmask_packer_chk #(.NCH(NCH), .AW(AW), .REC_W(REC_W), .RECS(RECS_PER_PKT)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_fire(ev_fire),
  .rec_full(rec_full), .hdr_phase(hdr_phase), .pk_valid(pk_valid), .pk_ready(pk_ready),
  .pk_data(pk_data), .pk_last(pk_last), .crd_valid(crd_valid), .crd_idx(crd_idx),
  .crd_bad(crd_bad), .rd_valid(rd_valid), .rd_chan(rd_chan), .crd_err(crd_err)
);

// File: tb/hitmask_packer_tb_top.sv
`timescale 1ns/1ps
module hitmask_packer_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          thr_we = 1'b0;
  logic [7:0]    thr_addr = '0;
  logic [11:0]   thr_data = '0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic [3071:0] ev_vals = '0;
  logic          pk_valid;
  logic          pk_ready = 1'b1;
  logic [255:0]  pk_data;
  logic          pk_last;
  logic          crd_valid = 1'b0;
  logic [8:0]    crd_idx = '0;
  logic          rd_valid;
  logic [7:0]    rd_chan;
  logic [11:0]   rd_data;
  logic          crd_err;

  always #2.5 clk = ~clk;

  hitmask_packer dut_i (.*);

  int checks = 0, errors = 0;
  logic [11:0]  thr_m [256];
  logic [11:0]  cur [256];
  logic [11:0]  last_ev [256];
  logic [255:0] exp_data [$];
  bit           exp_last [$];
  bit           exp_hdr [$];
  int           slot_m = 0, evnum_m = 0, got_beats = 0, sent_beats = 0;
  bit           bp_on = 1'b0, mon_on = 1'b0;
  int unsigned  seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor and ready driver
  logic [255:0] prev_data;
  logic         prev_last;
  bit           prev_stall = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      pk_ready = bp_on ? (rnd() % 3 != 0) : 1'b1;
      if (prev_stall) begin
        chk(pk_valid && pk_data == prev_data && pk_last == prev_last, "R6 hold", pk_data, prev_data);
      end
      if (pk_valid) begin
        if (exp_data.size() == 0) begin
          chk(1'b0, "R7 unexpected beat", pk_data, '0);
        end else begin
          chk(pk_data == exp_data[0], exp_hdr[0] ? "R5 header" : "R2 R3 record", pk_data, exp_data[0]);
          chk(pk_last == exp_last[0], "R4 last flag", 256'(pk_last), 256'(exp_last[0]));
          if (pk_ready) begin
            void'(exp_data.pop_front()); void'(exp_last.pop_front()); void'(exp_hdr.pop_front());
            got_beats++;
          end
        end
      end
      prev_stall = pk_valid && !pk_ready;
      prev_data  = pk_data;
      prev_last  = pk_last;
    end
  end

  task automatic write_thr(input int ch, input logic [11:0] v);
    @(negedge clk);
    thr_we = 1'b1; thr_addr = 8'(ch); thr_data = v;
    @(negedge clk);
    thr_we = 1'b0;
    thr_m[ch] = v;   // R8: applies to later events
  endtask

  task automatic send_event();
    logic [255:0] m;
    @(negedge clk);
    for (int k = 0; k < 256; k++) ev_vals[k*12 +: 12] = cur[k];
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    m = '0;
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 64; c++)
        m[g*64 + c] = cur[g*64 + c] > thr_m[g*64 + c];
    if (slot_m == 0) begin
      exp_data.push_back({216'd0, 8'd25, 32'(evnum_m)}); exp_last.push_back(1'b0); exp_hdr.push_back(1'b1);
      sent_beats++;
    end
    exp_data.push_back(m); exp_last.push_back(slot_m == 24); exp_hdr.push_back(1'b0);
    sent_beats++;
    slot_m = (slot_m + 1) % 25;
    evnum_m++;
    for (int k = 0; k < 256; k++) last_ev[k] = cur[k];
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_data.size() != 0; i++) @(negedge clk);
    chk(exp_data.size() == 0, "R7 drained", 256'(exp_data.size()), '0);
  endtask

  task automatic ask(input int idx);
    @(negedge clk);
    crd_valid = 1'b1; crd_idx = 9'(idx);
    @(negedge clk);
    crd_valid = 1'b0;
    if (idx < 256) begin
      chk(rd_valid == 1'b1, "R9 valid", 256'(rd_valid), 256'(1));
      chk(rd_chan == 8'(idx), "R9 chan", 256'(rd_chan), 256'(idx));
      chk(rd_data == last_ev[idx], "R9 data", 256'(rd_data), 256'(last_ev[idx]));
    end else begin
      chk(rd_valid == 1'b0, "R10 no readout", 256'(rd_valid), '0);
      chk(crd_err == 1'b1, "R10 error flag", 256'(crd_err), 256'(1));
    end
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin thr_m[k] = 12'hFFF; last_ev[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pk_valid == 1'b0, "R1 pk_valid", 256'(pk_valid), '0);
    chk(rd_valid == 1'b0, "R1 rd_valid", 256'(rd_valid), '0);
    chk(crd_err == 1'b0, "R1 crd_err", 256'(crd_err), '0);
    chk(ev_ready == 1'b1, "R1 ev_ready", 256'(ev_ready), 256'(1));
    mon_on = 1'b1;
    // R1: reset thresholds 4095, values 4095 give no hits
    for (int k = 0; k < 256; k++) cur[k] = 12'hFFF;
    send_event();
    // R8: program a ramp of thresholds
    for (int k = 0; k < 256; k++) write_thr(k, 12'(k * 16));
    // R2: equal gives no hit, one above gives hit
    for (int k = 0; k < 256; k++) cur[k] = 12'(k * 16);
    send_event();
    for (int k = 0; k < 256; k++) cur[k] = 12'(k * 16 + 1);
    send_event();
    // R3: walking hit per group
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 256; k++) cur[k] = '0;
      cur[g*64 + 5*g + 1] = 12'hFFF;
      send_event();
    end
    // R4 R5 R6 R7: random values under stalls across packets
    bp_on = 1'b1;
    for (int e = 0; e < 43; e++) begin
      for (int k = 0; k < 256; k++) cur[k] = 12'(rnd());
      send_event();
    end
    drain();
    bp_on = 1'b0;
    chk(got_beats == sent_beats && got_beats == 52, "R4 beat count", 256'(got_beats), 256'(52));
    // R9 R10 coordinates
    ask(0); ask(63); ask(64); ask(255); ask(128);
    ask(256); ask(511);
    ask(7);
    chk(crd_err == 1'b1, "R10 sticky", 256'(crd_err), 256'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule